// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the queue of physical register numbers that no in-flight instruction currently owns. The renamer asks for several numbers in one cycle. If the queue holds enough, the block grants all of them and removes them from the head. Retirement returns the old mappings that newer retiring writes have made dead, several per cycle, at the tail.

The queue is a circular buffer with three pointers. The speculative head moves on every grant. The committed head moves only when allocations retire. The tail moves on every reclaim. A branch misprediction sets the speculative head back to the committed head in one cycle. That single step hands every speculative allocation back to the queue. Each pointer carries one extra wrap bit, so full and empty are never confused.

Top module: `phys_free_list`

## Requirements
- R1: After reset the queue holds the numbers NUM_LOG to NUM_PHYS-1 in ascending order (16 to 63 with defaults). Both heads point at the first of these numbers.
- R2: When allocCnt is between 1 and the free count, and flush is low, allocGrant is 1 in the same cycle. Lane i of allocPreg (bits i*6 up to i*6+5 with defaults) carries the number at the speculative head plus i. The speculative head then moves by allocCnt.
- R3: When allocCnt is greater than the free count and flush is low, allocStall is 1 and allocGrant is 0. No number is consumed, so the next grant returns the same numbers.
- R4: Each valid reclaim lane writes its number at the tail in lane order, lowest lane first, and invalid lanes are skipped. The tail moves by the number of valid lanes.
- R5: commitCnt moves the committed head forward by that count in the same cycle.
- R6: While flush is high there is no grant and no stall. The speculative head is then set to the committed head, including any commitCnt applied in that cycle.
- R7: When an allocation and a reclaim arrive in the same cycle, the grant decision uses the free count from the start of the cycle. Both operations are applied.
- R8: Across wrap-around of the buffer, the entries between the committed head and the tail never exceed NUM_PHYS-NUM_LOG.
- R9: With allocCnt at 0 both allocGrant and allocStall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocCnt | input | $clog2(ALLOC_W+1) | Number of destinations to allocate this cycle |
| allocGrant | output | 1 | All requested numbers granted |
| allocStall | output | 1 | Request exceeds the free count; nothing granted |
| allocPreg | output | ALLOC_W*$clog2(NUM_PHYS) | Granted numbers, lane 0 in the low bits; zero when there is no grant |
| reclaimValid | input | RECL_W | Per-lane valid for returned numbers |
| reclaimPreg | input | RECL_W*$clog2(NUM_PHYS) | Returned numbers, lane 0 in the low bits |
| commitCnt | input | $clog2(RECL_W+1) | Retired allocations this cycle |
| flush | input | 1 | Misprediction recovery: restore the speculative head |

## Verification
The hardest case to reach is a recovery that lands after the buffer pointers have wrapped, with sparse reclaim lanes sitting between the committed and speculative heads. Directed steps first drain the queue to a stall. They then push a request and a reclaim into the same empty cycle, flush after a partial commit, and return a mask with gaps in its valid lanes. A long pseudo-random sweep then wraps the pointers many times while the bench's own queue model predicts every granted number. Reclaims in the sweep are limited to the free room.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef struct packed {
    logic wrEn;   // at least one reclaim lane valid
    logic grant;  // allocation accepted this cycle
  } flStrobe_t;

  function automatic int unsigned countBits(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import fl_pkg::*;
#(
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 16,
  parameter int ALLOC_W  = 5,
  parameter int RECL_W   = 8,
  localparam int PTR_W   = $clog2(NUM_PHYS) + 1,
  localparam int AC_W    = $clog2(ALLOC_W + 1),
  localparam int RC_W    = $clog2(RECL_W + 1),
  localparam int CAP     = NUM_PHYS - NUM_LOG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AC_W-1:0]   allocCnt,
  input  logic [RC_W-1:0]   commitCnt,
  input  logic              flush,
  input  logic [RECL_W-1:0] reclaimValid,
  output flStrobe_t         strobe,
  output logic [PTR_W-1:0]  specHead,
  output logic [PTR_W-1:0]  commitHead,
  output logic [PTR_W-1:0]  tail,
  output logic              allocGrant,
  output logic              allocStall
);

  logic [PTR_W-1:0] freeCnt;
  logic [PTR_W-1:0] reqAmt;
  logic [PTR_W-1:0] recAmt;
  logic [PTR_W-1:0] commitNext;
  logic             enough;
  logic             anyReq;

  always_comb begin
    freeCnt    = tail - specHead;
    reqAmt     = PTR_W'(allocCnt);
    recAmt     = PTR_W'(countBits(32'(reclaimValid)));
    commitNext = commitHead + PTR_W'(commitCnt);
    enough     = (reqAmt <= freeCnt);
    anyReq     = (allocCnt != '0) && !flush;
    allocGrant = anyReq && enough;
    allocStall = anyReq && !enough;
    strobe.grant = allocGrant;
    strobe.wrEn  = (reclaimValid != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specHead   <= '0;
      commitHead <= '0;
      tail       <= PTR_W'(CAP);
    end else begin
      commitHead <= commitNext;
      tail       <= tail + recAmt;
      if (flush)
        specHead <= commitNext;
      else if (allocGrant)
        specHead <= specHead + reqAmt;
    end
  end

endmodule

// File: rtl/fl_data.sv
module fl_data
  import fl_pkg::*;
#(
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 16,
  parameter int ALLOC_W  = 5,
  parameter int RECL_W   = 8,
  localparam int IDX_W   = $clog2(NUM_PHYS),
  localparam int PREG_W  = $clog2(NUM_PHYS),
  localparam int PTR_W   = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  flStrobe_t                strobe,
  input  logic [PTR_W-1:0]         rdBase,
  input  logic [PTR_W-1:0]         wrBase,
  input  logic [RECL_W-1:0]        reclaimValid,
  input  logic [RECL_W*PREG_W-1:0] reclaimPreg,
  output logic [ALLOC_W*PREG_W-1:0] allocPreg
);

  logic [PREG_W-1:0] store [NUM_PHYS];
  logic [IDX_W-1:0]  slot  [RECL_W];

  for (genvar g = 0; g < ALLOC_W; g++) begin : g_rdLane
    assign allocPreg[g*PREG_W +: PREG_W] =
      strobe.grant ? store[IDX_W'(rdBase + PTR_W'(g))] : '0;
  end

  always_comb begin
    logic [IDX_W-1:0] run;
    run = IDX_W'(wrBase);
    for (int i = 0; i < RECL_W; i++) begin
      slot[i] = run;
      if (reclaimValid[i]) run = run + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PHYS; k++) store[k] <= PREG_W'(k + NUM_LOG);
    end else if (strobe.wrEn) begin
      for (int i = 0; i < RECL_W; i++)
        if (reclaimValid[i]) store[slot[i]] <= reclaimPreg[i*PREG_W +: PREG_W];
    end
  end

endmodule

// File: rtl/phys_free_list.sv
module phys_free_list
  import fl_pkg::*;
#(
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 16,
  parameter int ALLOC_W  = 5,
  parameter int RECL_W   = 8,
  localparam int PREG_W  = $clog2(NUM_PHYS),
  localparam int PTR_W   = PREG_W + 1,
  localparam int AC_W    = $clog2(ALLOC_W + 1),
  localparam int RC_W    = $clog2(RECL_W + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [AC_W-1:0]           allocCnt,
  output logic                      allocGrant,
  output logic                      allocStall,
  output logic [ALLOC_W*PREG_W-1:0] allocPreg,
  input  logic [RECL_W-1:0]         reclaimValid,
  input  logic [RECL_W*PREG_W-1:0]  reclaimPreg,
  input  logic [RC_W-1:0]           commitCnt,
  input  logic                      flush
);

  flStrobe_t        strobe;
  logic [PTR_W-1:0] specHead;
  logic [PTR_W-1:0] commitHead;
  logic [PTR_W-1:0] tail;

  fl_ctrl #(
    .NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG), .ALLOC_W(ALLOC_W), .RECL_W(RECL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .allocCnt(allocCnt), .commitCnt(commitCnt),
    .flush(flush), .reclaimValid(reclaimValid), .strobe(strobe),
    .specHead(specHead), .commitHead(commitHead), .tail(tail),
    .allocGrant(allocGrant), .allocStall(allocStall)
  );

  fl_data #(
    .NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG), .ALLOC_W(ALLOC_W), .RECL_W(RECL_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdBase(specHead), .wrBase(tail),
    .reclaimValid(reclaimValid), .reclaimPreg(reclaimPreg), .allocPreg(allocPreg)
  );

endmodule

// File: rtl/phys_free_list_chk.sv
module phys_free_list_chk #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 16,
  parameter int ALLOC_W  = 5,
  parameter int RECL_W   = 8,
  localparam int PTR_W   = $clog2(NUM_PHYS) + 1,
  localparam int AC_W    = $clog2(ALLOC_W + 1),
  localparam int RC_W    = $clog2(RECL_W + 1),
  localparam int CAP     = NUM_PHYS - NUM_LOG
) (
  input logic              clk,
  input logic              rstN,
  input logic [AC_W-1:0]   allocCnt,
  input logic              allocGrant,
  input logic              allocStall,
  input logic [RECL_W-1:0] reclaimValid,
  input logic [RC_W-1:0]   commitCnt,
  input logic              flush,
  input logic [PTR_W-1:0]  specHead,
  input logic [PTR_W-1:0]  commitHead,
  input logic [PTR_W-1:0]  tail
);

  logic [PTR_W-1:0] occupied;
  logic [PTR_W-1:0] inFlight;
  assign occupied = tail - commitHead;
  assign inFlight = specHead - commitHead;

  p_occupancy_r8: assert property (@(posedge clk) disable iff (!rstN)
    occupied <= PTR_W'(CAP));

  p_inflight_r8: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= occupied);

  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(allocGrant && allocStall));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    allocStall |=> $stable(specHead));

  p_grant_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |=> specHead == $past(specHead) + PTR_W'($past(allocCnt)));

  p_tail_move_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> tail == $past(tail) + PTR_W'($countones($past(reclaimValid))));

  p_commit_move_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> commitHead == $past(commitHead) + PTR_W'($past(commitCnt)));

  p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !allocGrant && !allocStall);

  p_flush_restore_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> specHead == commitHead);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (allocCnt == '0) |-> !allocGrant && !allocStall);

endmodule

bind phys_free_list phys_free_list_chk #(
  .NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG), .ALLOC_W(ALLOC_W), .RECL_W(RECL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .allocCnt(allocCnt), .allocGrant(allocGrant),
  .allocStall(allocStall), .reclaimValid(reclaimValid), .commitCnt(commitCnt),
  .flush(flush), .specHead(specHead), .commitHead(commitHead), .tail(tail)
);

// File: tb/phys_free_list_bench.sv
module phys_free_list_bench;

  localparam int NP = 64;
  localparam int NL = 16;
  localparam int AW = 5;
  localparam int RW = 8;
  localparam int PW = 6;
  localparam int CAP = NP - NL;
  localparam int MSZ = 8192;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [2:0]     allocCnt = '0;
  logic           allocGrant;
  logic           allocStall;
  logic [AW*PW-1:0] allocPreg;
  logic [RW-1:0]  reclaimValid = '0;
  logic [RW*PW-1:0] reclaimPreg = '0;
  logic [3:0]     commitCnt = '0;
  logic           flush = 1'b0;

  int errors = 0;
  int checks = 0;
  int mSpec, mCommit, mTail;
  int modelMem [MSZ];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  phys_free_list u_phys_free_list (
    .clk(clk), .rstN(rstN), .allocCnt(allocCnt), .allocGrant(allocGrant),
    .allocStall(allocStall), .allocPreg(allocPreg), .reclaimValid(reclaimValid),
    .reclaimPreg(reclaimPreg), .commitCnt(commitCnt), .flush(flush)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int aCnt, input logic [RW-1:0] rMask,
                      input logic [RW*PW-1:0] rVals, input int cCnt,
                      input bit fl, input string tag);
    int freeN;
    bit expGrant, expStall;
    @(negedge clk);
    allocCnt = 3'(aCnt);
    reclaimValid = rMask;
    reclaimPreg = rVals;
    commitCnt = 4'(cCnt);
    flush = fl;
    #1;
    freeN = mTail - mSpec;
    expGrant = !fl && aCnt != 0 && aCnt <= freeN;
    expStall = !fl && aCnt != 0 && aCnt > freeN;
    check({tag, " grant"}, int'(allocGrant), int'(expGrant));
    check({tag, " stall"}, int'(allocStall), int'(expStall));
    if (expGrant)
      for (int i = 0; i < aCnt; i++)
        check({tag, " lane"}, int'(allocPreg[i*PW +: PW]),
              modelMem[(mSpec + i) % MSZ]);
    for (int i = 0; i < RW; i++)
      if (rMask[i]) begin
        modelMem[mTail % MSZ] = int'(rVals[i*PW +: PW]);
        mTail++;
      end
    mCommit += cCnt;
    if (fl) mSpec = mCommit;
    else if (expGrant) mSpec += aCnt;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < MSZ; k++) modelMem[k] = 0;
    for (int k = 0; k < CAP; k++) modelMem[k] = NL + k;   // R1 reset order
    mSpec = 0; mCommit = 0; mTail = CAP;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    step(0, '0, '0, 0, 0, "R9 idle after reset");
    for (int n = 0; n < 9; n++) step(5, '0, '0, 0, 0, "R1 reset content");
    step(5, '0, '0, 0, 0, "R3 short list");
    step(3, '0, '0, 0, 0, "R2 partial width");
    step(1, '0, '0, 0, 0, "R3 empty list");
    step(0, '0, '0, 8, 0, "R5 commit");
    step(1, 8'b0000_0011, {36'd0, 6'd41, 6'd40}, 0, 0, "R7 same-cycle");
    step(2, '0, '0, 0, 0, "R7 after reclaim");
    step(2, '0, '0, 0, 1, "R6 flush");
    step(5, '0, '0, 0, 0, "R6 restored");
    step(0, '0, '0, 5, 0, "R5 commit two");
    step(4, '0, '0, 2, 1, "R6 flush with commit");
    step(0, 8'b1010_0101,
         {6'd33, 6'd9, 6'd34, 6'd8, 6'd9, 6'd35, 6'd9, 6'd36}, 0, 0,
         "R4 sparse reclaim");
    while (mTail - mSpec > 0) begin
      int take;
      take = (mTail - mSpec > AW) ? AW : (mTail - mSpec);
      step(take, '0, '0, 0, 0, "R4 drain order");
    end
    step(1, '0, '0, 0, 0, "R3 drained");

    for (int n = 0; n < 4000; n++) begin
      int aC, cC, room, pop;
      logic [RW-1:0] m;
      logic [RW*PW-1:0] v;
      bit fl;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      aC = int'(lfsr[2:0]) % (AW + 1);
      cC = int'(lfsr[5:4]);
      if (cC > mSpec - mCommit) cC = mSpec - mCommit;
      room = CAP - (mTail - mCommit) + cC;
      m = lfsr[13:6] & {lfsr[1:0], lfsr[15:10]};
      pop = 0;
      for (int i = 0; i < RW; i++)
        if (m[i]) begin
          if (pop < room) pop++;
          else m[i] = 1'b0;
        end
      for (int i = 0; i < RW; i++) v[i*PW +: PW] = PW'(n + 7 * i);
      fl = (lfsr[15:11] == 5'd0);
      step(aC, m, v, cC, fl, "R8 sweep");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule